// File: doc/BRIEF.md
# Legacy-Zero Single-Precision Multiplier

This unit multiplies two single-precision floating-point operands and applies a zero rule that differs from IEEE-754. It decodes a 9-bit operation code together with a generation select and runs one of three operations: a legacy multiply, a legacy multiply-accumulate qualifier, or a standard multiply. In the legacy operations, an operand that counts as zero decides the outcome, even when the other operand is infinity or NaN. The legacy multiply then returns +0.0. The legacy multiply-accumulate instead drops its destination write, so the accumulator keeps its value.

The accumulate addition itself sits downstream. For a multiply-accumulate with two non-zero operands, the unit delivers the rounded product with the write enabled. The unit accepts one operation per clock with no stall, and every result appears exactly two clocks after its inputs. Denormal values are treated as zero on input and flushed on output. Exception flags are not produced.

Top module: `lzm_mul_unit`

## Requirements
- R1: Legacy multiply with an operand whose exponent field is 0 (either sign, including denormals) gives prod_o = 0x00000000 with wr_en_o = 1, whatever the other operand holds, Inf and NaN included.
- R2: Legacy multiply-accumulate with an operand whose exponent field is 0 gives res_vld_o = 1 and wr_en_o = 0. With both operands non-zero it gives the rounded product with wr_en_o = 1.
- R3: Standard multiply follows IEEE rules for zeros. Zero times Inf gives 0x7FC00000, and zero times a finite value gives a zero whose sign is the XOR of the operand signs.
- R4: With gen_i = 0, the codes are 6 and 262 for legacy multiply-accumulate, 7 and 263 for legacy multiply, and 8 and 264 for standard multiply.
- R5: With gen_i = 1, the codes are 4 and 260 for legacy multiply and 5 and 261 for standard multiply. No code selects multiply-accumulate in this generation.
- R6: A code not listed for the selected generation, or vld_i = 0, gives res_vld_o = 0, wr_en_o = 0 and prod_o = 0 two cycles later. wr_en_o is never high without res_vld_o.
- R7: A finite non-zero product is rounded to nearest with ties to even.
- R8: A product whose biased exponent reaches 255 after rounding gives an infinity carrying the XOR of the operand signs.
- R9: A NaN operand without a zero partner in a legacy operation gives the canonical quiet NaN 0x7FC00000.
- R10: A product whose biased exponent is 0 or below after rounding is flushed to a zero with the XOR of the operand signs. No output is ever denormal.
- R11: Each accepted input produces its result exactly two clock edges later, and back-to-back inputs produce back-to-back results.
- R12: While rst_n is low, prod_o, wr_en_o and res_vld_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Input operation strobe |
| gen_i | input | 1 | Opcode generation select (0 first, 1 later) |
| opc_i | input | 9 | Operation code, short or long form |
| src_a_i | input | 32 | First single-precision operand |
| src_b_i | input | 32 | Second single-precision operand |
| prod_o | output | 32 | Rounded or forced product |
| wr_en_o | output | 1 | Destination write enable |
| res_vld_o | output | 1 | Result valid |

## Verification
The clocked properties assume that vld_i, gen_i, opc_i and both operands are known (not X) in every cycle after reset is released. They also assume that inputs only change away from the rising edge. The bench drives every input on the falling edge and keeps vld_i low and the operands at zero while reset is asserted. It issues an operation, or an explicit idle, in every cycle, so the two-cycle latency properties always see defined values. Random operands are biased toward exponent fields of 0 and 255, so that the zero, infinity and NaN paths are hit often.

// File: rtl/lzm_pkg.sv
package lzm_pkg;

    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 23;
    localparam int FP_W     = 1 + EXP_W + FRAC_W;
    localparam int SIG_W    = FRAC_W + 1;
    localparam int PROD_W   = 2 * SIG_W;
    localparam int EXP_MAX  = (1 << EXP_W) - 1;
    localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
    localparam int ESUM_W   = EXP_W + 3;

    localparam int OPC_W    = 9;
    localparam int LONG_OFS = 256;

    // per-generation short codes; long form adds LONG_OFS
    localparam int G0_LMAC  = 6;
    localparam int G0_LMUL  = 7;
    localparam int G0_SMUL  = 8;
    localparam int G1_LMUL  = 4;
    localparam int G1_SMUL  = 5;

    localparam logic [FP_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_LMUL = 2'd1,
        OP_LMAC = 2'd2,
        OP_SMUL = 2'd3
    } op_e;

    typedef struct packed {
        op_e                       op;
        logic                      sign;
        logic                      any_zero;
        logic                      any_inf;
        logic                      any_nan;
        logic signed [ESUM_W-1:0]  esum;
        logic [PROD_W-1:0]         prod;
    } raw_t;

    typedef struct packed {
        logic            vld;
        logic            wr;
        logic [FP_W-1:0] res;
    } res_t;

    // exponent field of zero: true zero or denormal (flushed)
    function automatic logic fp_is_zero(input logic [FP_W-1:0] x);
        return x[FP_W-2 -: EXP_W] == '0;
    endfunction

endpackage

// File: rtl/lzm_decode.sv
module lzm_decode
    import lzm_pkg::*;
(
    input  logic             gen_i,
    input  logic [OPC_W-1:0] opc_i,
    output op_e              op_o
);

    function automatic logic hit(input logic [OPC_W-1:0] o, input int code);
        return (o == OPC_W'(code)) || (o == OPC_W'(LONG_OFS + code));
    endfunction

    always_comb begin
        op_o = OP_NONE;
        if (!gen_i) begin
            if (hit(opc_i, G0_LMAC))      op_o = OP_LMAC;
            else if (hit(opc_i, G0_LMUL)) op_o = OP_LMUL;
            else if (hit(opc_i, G0_SMUL)) op_o = OP_SMUL;
        end else begin
            if (hit(opc_i, G1_LMUL))      op_o = OP_LMUL;
            else if (hit(opc_i, G1_SMUL)) op_o = OP_SMUL;
        end
    end

    always_comb begin
        if (gen_i) begin
            AST_LATER_NO_MAC: assert (op_o != OP_LMAC); // R5
        end
    end

endmodule

// File: rtl/lzm_unpack.sv
module lzm_unpack
    import lzm_pkg::*;
(
    input  op_e             op_i,
    input  logic [FP_W-1:0] a_i,
    input  logic [FP_W-1:0] b_i,
    output raw_t            raw_o
);

    logic [EXP_W-1:0]  ea_d, eb_d;
    logic [FRAC_W-1:0] fa_d, fb_d;
    logic [SIG_W-1:0]  sa_d, sb_d;
    logic              za_d, zb_d, ia_d, ib_d, na_d, nb_d;

    always_comb begin
        ea_d = a_i[FP_W-2 -: EXP_W];
        eb_d = b_i[FP_W-2 -: EXP_W];
        fa_d = a_i[FRAC_W-1:0];
        fb_d = b_i[FRAC_W-1:0];

        za_d = (ea_d == '0);
        zb_d = (eb_d == '0);
        ia_d = (ea_d == '1) && (fa_d == '0);
        ib_d = (eb_d == '1) && (fb_d == '0);
        na_d = (ea_d == '1) && (fa_d != '0);
        nb_d = (eb_d == '1) && (fb_d != '0);

        sa_d = {1'b1, fa_d};
        sb_d = {1'b1, fb_d};

        raw_o.op       = op_i;
        raw_o.sign     = a_i[FP_W-1] ^ b_i[FP_W-1];
        raw_o.any_zero = za_d | zb_d;
        raw_o.any_inf  = ia_d | ib_d;
        raw_o.any_nan  = na_d | nb_d;
        raw_o.esum     = ESUM_W'(ea_d) + ESUM_W'(eb_d) - ESUM_W'(BIAS);
        raw_o.prod     = PROD_W'(sa_d) * PROD_W'(sb_d);
    end

endmodule

// File: rtl/lzm_round.sv
module lzm_round
    import lzm_pkg::*;
(
    input  raw_t raw_i,
    output res_t res_o
);

    localparam int G_HI = PROD_W - 1 - SIG_W;
    localparam int G_LO = G_HI - 1;

    logic                     hi_d;
    logic [SIG_W-1:0]         keep_d;
    logic                     guard_d, sticky_d, inc_d;
    logic [SIG_W:0]           rnd_d;
    logic [1:0]               bump_d;
    logic signed [ESUM_W-1:0] efin_d;
    logic [FP_W-1:0]          norm_d;
    logic                     legacy_d;

    always_comb begin
        hi_d     = raw_i.prod[PROD_W-1];
        keep_d   = hi_d ? raw_i.prod[PROD_W-1 -: SIG_W] : raw_i.prod[PROD_W-2 -: SIG_W];
        guard_d  = hi_d ? raw_i.prod[G_HI] : raw_i.prod[G_LO];
        sticky_d = hi_d ? (|raw_i.prod[G_HI-1:0]) : (|raw_i.prod[G_LO-1:0]);
        inc_d    = guard_d & (sticky_d | keep_d[0]);
        rnd_d    = {1'b0, keep_d} + (SIG_W+1)'(inc_d);
        bump_d   = {1'b0, hi_d} + {1'b0, rnd_d[SIG_W]};
        efin_d   = raw_i.esum + $signed({{(ESUM_W-2){1'b0}}, bump_d});

        if (efin_d >= $signed(ESUM_W'(EXP_MAX))) begin
            norm_d = {raw_i.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (efin_d <= $signed(ESUM_W'(0))) begin
            norm_d = {raw_i.sign, {(FP_W-1){1'b0}}};
        end else begin
            norm_d = {raw_i.sign, efin_d[EXP_W-1:0], rnd_d[FRAC_W-1:0]};
        end

        legacy_d = (raw_i.op == OP_LMUL) || (raw_i.op == OP_LMAC);

        res_o = '0;
        if (raw_i.op != OP_NONE) begin
            res_o.vld = 1'b1;
            res_o.wr  = 1'b1;
            if (legacy_d && raw_i.any_zero) begin
                res_o.res = '0;
                res_o.wr  = (raw_i.op == OP_LMUL);
            end else if (raw_i.any_nan || (raw_i.any_inf && raw_i.any_zero)) begin
                res_o.res = QNAN;
            end else if (raw_i.any_inf) begin
                res_o.res = {raw_i.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            end else if (raw_i.any_zero) begin
                res_o.res = {raw_i.sign, {(FP_W-1){1'b0}}};
            end else begin
                res_o.res = norm_d;
            end
        end
    end

    always_comb begin
        if (res_o.vld && (res_o.res[FP_W-2 -: EXP_W] == '0)) begin
            AST_NO_DENORM_OUT: assert (res_o.res[FRAC_W-1:0] == '0); // R10
        end
    end

endmodule

// File: rtl/lzm_mul_unit.sv
module lzm_mul_unit
    import lzm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic             gen_i,
    input  logic [OPC_W-1:0] opc_i,
    input  logic [FP_W-1:0]  src_a_i,
    input  logic [FP_W-1:0]  src_b_i,
    output logic [FP_W-1:0]  prod_o,
    output logic             wr_en_o,
    output logic             res_vld_o
);

    typedef struct packed {
        raw_t s1;
        res_t s2;
    } pipe_t;

    op_e   dec_op;
    op_e   op_gated;
    raw_t  raw_now;
    res_t  res_now;
    pipe_t pipe_d, pipe_q;

    lzm_decode u_dec (
        .gen_i (gen_i),
        .opc_i (opc_i),
        .op_o  (dec_op)
    );

    assign op_gated = vld_i ? dec_op : OP_NONE;

    lzm_unpack u_unp (
        .op_i  (op_gated),
        .a_i   (src_a_i),
        .b_i   (src_b_i),
        .raw_o (raw_now)
    );

    lzm_round u_rnd (
        .raw_i (pipe_q.s1),
        .res_o (res_now)
    );

    always_comb begin
        pipe_d    = pipe_q;
        pipe_d.s1 = raw_now;
        pipe_d.s2 = res_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign prod_o    = pipe_q.s2.res;
    assign wr_en_o   = pipe_q.s2.wr;
    assign res_vld_o = pipe_q.s2.vld;

    AST_WR_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> res_vld_o); // R6

    AST_ACCEPT_LAT2: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && dec_op != OP_NONE) |=> ##1 res_vld_o); // R11

    AST_DROP_LAT2: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld_i && dec_op != OP_NONE) |=> ##1 (!res_vld_o && !wr_en_o)); // R6

    AST_LEGACY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && dec_op == OP_LMUL && (fp_is_zero(src_a_i) || fp_is_zero(src_b_i)))
        |=> ##1 (prod_o == '0 && wr_en_o && res_vld_o)); // R1

    AST_MAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && dec_op == OP_LMAC && (fp_is_zero(src_a_i) || fp_is_zero(src_b_i)))
        |=> ##1 (res_vld_o && !wr_en_o)); // R2

endmodule

// File: tb/tb_lzm_mul_unit.sv
`timescale 1ns/1ps
module tb_lzm_mul_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld_i = 1'b0;
    logic        gen_i = 1'b0;
    logic [8:0]  opc_i = '0;
    logic [31:0] src_a_i = '0;
    logic [31:0] src_b_i = '0;
    logic [31:0] prod_o;
    logic        wr_en_o;
    logic        res_vld_o;

    always #2.5 clk = ~clk;

    lzm_mul_unit dut (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .gen_i(gen_i), .opc_i(opc_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i),
        .prod_o(prod_o), .wr_en_o(wr_en_o), .res_vld_o(res_vld_o)
    );

    typedef struct {
        int          due;
        logic        vld;
        logic        wr;
        logic [31:0] res;
        string       req;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    always @(posedge clk) cyc <= cyc + 1;

    // kind: 0 none, 1 legacy mul, 2 legacy mac, 3 standard mul
    function automatic int kind_of(input logic g, input logic [8:0] o, input logic v);
        int c;
        if (!v) return 0;
        if (o < 9'd64)       c = int'(o);
        else if (o >= 9'd256 && o < 9'd320) c = int'(o) - 256;
        else return 0;
        if (!g) begin
            if (c == 6) return 2;
            if (c == 7) return 1;
            if (c == 8) return 3;
        end else begin
            if (c == 4) return 1;
            if (c == 5) return 3;
        end
        return 0;
    endfunction

    function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] b, input int kind);
        bit za, zb, ia, ib, na, nb, s;
        longint p, m, r, h;
        int e, sh;
        if (kind == 0) return '0;
        za = (a[30:23] == 0); zb = (b[30:23] == 0);
        ia = (a[30:23] == 8'hFF) && (a[22:0] == 0);
        ib = (b[30:23] == 8'hFF) && (b[22:0] == 0);
        na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
        nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        s  = a[31] ^ b[31];
        if (kind != 3 && (za || zb)) return {1'b1, (kind == 1), 32'h0};
        if (na || nb || ((ia || ib) && (za || zb))) return {2'b11, 32'h7FC0_0000};
        if (ia || ib) return {2'b11, s, 8'hFF, 23'h0};
        if (za || zb) return {2'b11, s, 31'h0};
        p  = longint'({1'b1, a[22:0]}) * longint'({1'b1, b[22:0]});
        e  = int'(a[30:23]) + int'(b[30:23]) - 127;
        sh = 23;
        if (p >= (64'sd1 << 47)) begin sh = 24; e = e + 1; end
        m = p >>> sh;
        r = p - (m <<< sh);
        h = 64'sd1 <<< (sh - 1);
        if (r > h || (r == h && m[0])) m = m + 1;
        if (m == (64'sd1 << 24)) begin m = m >>> 1; e = e + 1; end
        if (e >= 255) return {2'b11, s, 8'hFF, 23'h0};
        if (e <= 0)   return {2'b11, s, 31'h0};
        return {2'b11, s, e[7:0], m[22:0]};
    endfunction

    task automatic push_exp(input logic v, input logic w, input logic [31:0] r, input string req);
        exp_t it;
        it.due = cyc + 2; it.vld = v; it.wr = w; it.res = r; it.req = req;
        sb.push_back(it);
    endtask

    // drive one cycle with an explicit expectation
    task automatic drive_exp(input logic g, input logic [8:0] o, input logic v,
                             input logic [31:0] a, input logic [31:0] b,
                             input logic ev, input logic ew, input logic [31:0] er, input string req);
        @(negedge clk);
        gen_i = g; opc_i = o; vld_i = v; src_a_i = a; src_b_i = b;
        push_exp(ev, ew, er, req);
    endtask

    // drive one cycle, expectation from the model
    task automatic drive_mdl(input logic g, input logic [8:0] o, input logic v,
                             input logic [31:0] a, input logic [31:0] b, input string req);
        logic [33:0] x;
        x = model(a, b, kind_of(g, o, v));
        drive_exp(g, o, v, a, b, x[33], x[32], x[31:0], req);
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // monitor: compare due items after the edge
    always @(posedge clk) begin
        #1;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t it;
            it = sb.pop_front();
            n_chk++;
            if (it.due != cyc || res_vld_o !== it.vld || wr_en_o !== it.wr || prod_o !== it.res) begin
                n_fail++;
                $display("FAIL %s: got vld=%b wr=%b res=%h, expected vld=%b wr=%b res=%h",
                         it.req, res_vld_o, wr_en_o, prod_o, it.vld, it.wr, it.res);
            end
        end
    end

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got running, expected finished");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        n_chk++;
        if (prod_o !== 32'h0 || wr_en_o !== 1'b0 || res_vld_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R12: got vld=%b wr=%b res=%h, expected vld=0 wr=0 res=00000000",
                     res_vld_o, wr_en_o, prod_o);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1 legacy multiply zero override
        drive_exp(0, 9'd7, 1, 32'h0000_0000, 32'h7F80_0000, 1, 1, 32'h0, "R1 zero*inf");
        drive_exp(0, 9'd7, 1, 32'h8000_0000, 32'h7FC0_0001, 1, 1, 32'h0, "R1 -zero*nan");
        drive_exp(0, 9'd7, 1, 32'h0000_0005, 32'h4000_0000, 1, 1, 32'h0, "R1 denorm*2");
        drive_exp(0, 9'd7, 1, 32'hC040_0000, 32'h8000_0000, 1, 1, 32'h0, "R1 -3*-zero");
        // R2 legacy accumulate qualifier
        drive_exp(0, 9'd6, 1, 32'h0000_0000, 32'h4040_0000, 1, 0, 32'h0, "R2 zero hold");
        drive_exp(0, 9'd6, 1, 32'h7F80_0000, 32'h8000_0000, 1, 0, 32'h0, "R2 inf*zero hold");
        drive_exp(0, 9'd6, 1, 32'h4000_0000, 32'h4040_0000, 1, 1, 32'h40C0_0000, "R2 2*3");
        // R3 standard multiply
        drive_exp(0, 9'd8, 1, 32'h0000_0000, 32'h7F80_0000, 1, 1, 32'h7FC0_0000, "R3 zero*inf");
        drive_exp(0, 9'd8, 1, 32'h8000_0000, 32'h4000_0000, 1, 1, 32'h8000_0000, "R3 -zero*2");
        drive_exp(0, 9'd8, 1, 32'h3FC0_0000, 32'h3FC0_0000, 1, 1, 32'h4010_0000, "R3 1.5*1.5");
        // R4 long forms, first generation
        drive_exp(0, 9'd262, 1, 32'h0000_0000, 32'h4000_0000, 1, 0, 32'h0, "R4 long mac");
        drive_exp(0, 9'd263, 1, 32'h7F80_0000, 32'h0000_0000, 1, 1, 32'h0, "R4 long lmul");
        drive_exp(0, 9'd264, 1, 32'h4000_0000, 32'h4040_0000, 1, 1, 32'h40C0_0000, "R4 long smul");
        // R5 later generation
        drive_exp(1, 9'd4, 1, 32'h0000_0000, 32'h7F80_0000, 1, 1, 32'h0, "R5 lmul zero*inf");
        drive_exp(1, 9'd5, 1, 32'h0000_0000, 32'h7F80_0000, 1, 1, 32'h7FC0_0000, "R5 smul zero*inf");
        drive_exp(1, 9'd260, 1, 32'h4000_0000, 32'h4040_0000, 1, 1, 32'h40C0_0000, "R5 long lmul");
        drive_exp(1, 9'd261, 1, 32'h8000_0000, 32'h7F80_0000, 1, 1, 32'h7FC0_0000, "R5 long smul");
        drive_exp(1, 9'd6, 1, 32'h0000_0000, 32'h4000_0000, 0, 0, 32'h0, "R5 no mac code");
        // R6 unsupported or idle
        drive_exp(0, 9'd4, 1, 32'h4000_0000, 32'h4000_0000, 0, 0, 32'h0, "R6 gen0 code4");
        drive_exp(0, 9'd9, 1, 32'h4000_0000, 32'h4000_0000, 0, 0, 32'h0, "R6 code9");
        drive_exp(0, 9'd70, 1, 32'h4000_0000, 32'h4000_0000, 0, 0, 32'h0, "R6 code70");
        drive_exp(1, 9'd8, 1, 32'h4000_0000, 32'h4000_0000, 0, 0, 32'h0, "R6 gen1 code8");
        drive_exp(0, 9'd7, 0, 32'h4000_0000, 32'h4000_0000, 0, 0, 32'h0, "R6 vld low");
        // R7 ties to even
        drive_exp(0, 9'd8, 1, 32'h3F80_0001, 32'h3FC0_0000, 1, 1, 32'h3FC0_0002, "R7 tie odd up");
        drive_exp(0, 9'd8, 1, 32'h3F80_0003, 32'h3FC0_0000, 1, 1, 32'h3FC0_0004, "R7 tie even hold");
        // R8 overflow
        drive_exp(0, 9'd8, 1, 32'h7F00_0000, 32'h7F00_0000, 1, 1, 32'h7F80_0000, "R8 +ovf");
        drive_exp(1, 9'd4, 1, 32'hFF00_0000, 32'h7F00_0000, 1, 1, 32'hFF80_0000, "R8 -ovf");
        // R9 NaN canonical
        drive_exp(0, 9'd8, 1, 32'h7F80_0001, 32'h4000_0000, 1, 1, 32'h7FC0_0000, "R9 snan*2");
        drive_exp(0, 9'd7, 1, 32'hFFA0_0000, 32'h4000_0000, 1, 1, 32'h7FC0_0000, "R9 legacy nan*2");
        drive_exp(0, 9'd6, 1, 32'h3F80_0000, 32'h7FC0_1234, 1, 1, 32'h7FC0_0000, "R9 mac nan");
        // R10 underflow flush
        drive_exp(0, 9'd8, 1, 32'h0080_0000, 32'h3F00_0000, 1, 1, 32'h0000_0000, "R10 +uflow");
        drive_exp(0, 9'd8, 1, 32'h8080_0000, 32'h3F00_0000, 1, 1, 32'h8000_0000, "R10 -uflow");
        drive_exp(0, 9'd8, 1, 32'h0000_0001, 32'h7F00_0000, 1, 1, 32'h0000_0000, "R10 denorm in");
        // R11 back-to-back stream, alternating ops
        for (int i = 0; i < 6; i++) begin
            drive_mdl(i[0], (i[0] ? 9'd5 : 9'd7), 1, 32'h3F80_0000 + 32'(i << 20),
                      32'h4000_0000 + 32'(i), "R11 stream");
        end

        // random mix (R7 rounding / general)
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a, b, t;
            logic [8:0]  o;
            logic        g, v;
            lfsr = nxt(lfsr); a = lfsr;
            lfsr = nxt(lfsr); b = lfsr;
            lfsr = nxt(lfsr); t = lfsr;
            if (t[2:0] == 3'd0) a[30:23] = 8'h00;
            if (t[2:0] == 3'd1) b[30:23] = 8'hFF;
            if (t[5:3] == 3'd2) b[30:23] = 8'h00;
            if (t[5:3] == 3'd3) a[30:23] = 8'hFF;
            case (t[9:6])
                4'd0: o = 9'd4;   4'd1: o = 9'd5;   4'd2: o = 9'd6;
                4'd3: o = 9'd7;   4'd4: o = 9'd8;   4'd5: o = 9'd260;
                4'd6: o = 9'd261; 4'd7: o = 9'd262; 4'd8: o = 9'd263;
                4'd9: o = 9'd264; 4'd10: o = 9'd9;  default: o = 9'd7;
            endcase
            g = t[10];
            v = (t[13:11] != 3'd0);
            drive_mdl(g, o, v, a, b, "R7 random");
        end

        drive_exp(0, 9'd0, 0, 32'h0, 32'h0, 0, 0, 32'h0, "R6 tail idle");
        drive_exp(0, 9'd0, 0, 32'h0, 32'h0, 0, 0, 32'h0, "R6 tail idle");
        repeat (4) @(negedge clk);
        done = 1;
        report();
    end

endmodule